// File: doc/BRIEF.md
# Dataflow Destination Offset Resolver

This block sits behind the instruction decoder of a register-free dataflow machine. Each instruction names where its result goes as forward offsets, not as registers. The resolver takes the offset fields of one decoded instruction and turns them into absolute instruction indices for up to two consumers. It also flags the case where the instruction ends its block and hands its result back as the return value. The meaning of a zero first offset depends on the format. A regular instruction treats it as a block return. Each half of a compressed instruction treats it as a jump of eight instructions.

Alongside the resolver sits an operand collector. It holds a parameterised number of instruction slots, and the low bits of an instruction index select the slot. Each slot is given an expected input count between one and four. Arriving values fill operand positions 0, 1, 2 and 3 strictly in the order they reach the slot. When two values for the same slot arrive in one cycle, the one from the lower-indexed producer is placed first. A slot whose count matches its expectation is offered downstream together with its instruction index and ordered operands. When several slots are complete, the lowest-numbered one is offered. Once the offer is accepted, the slot is cleared. A value that arrives at a slot already holding four operands is discarded and raises an error pulse.

Top module: `dflow_dest_resolver`

## Requirements
- R1: After a synchronous reset the resolver result valid, the ready flag and the overflow error are all low.
- R2: One cycle after a decode is presented, the first destination index equals the current index plus the first offset, modulo 2^IDX_W, for any nonzero first offset.
- R3: A regular (non-compressed) instruction with a zero first offset sets the return flag one cycle later and marks both destinations invalid.
- R4: A compressed instruction with a zero first offset never returns; its first destination is the current index plus 8.
- R5: The second destination index equals the first destination index plus the second offset, so a zero second offset names the same instruction. It is marked valid only when the decode declares two destinations and the instruction does not return.
- R6: Values arriving at one slot over successive cycles occupy operand positions 0 to 3 in arrival order. Position k sits at bits [k*DATA_W +: DATA_W] of the operand bus.
- R7: When both arrival ports target the same slot in one cycle, the value with the smaller producer index takes the lower operand position. On equal producer indices, port 0 goes first.
- R8: A slot is ready exactly when its arrival count equals a nonzero expected count. With several slots ready, the lowest slot number is offered, together with the full instruction index given when its count was written.
- R9: An arrival at a slot already holding four operands is dropped with no change to the stored operands, and the overflow error is high for the following cycle.
- R10: Asserting accept while a slot is offered clears that slot: it leaves the ready set and the next ready slot, if any, is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_vld | input | 1 | Decoded offsets present this cycle |
| dec_cmp | input | 1 | Offsets come from a compressed half |
| dec_two | input | 1 | Instruction names a second destination |
| dec_cur | input | IDX_W | Index of the decoded instruction |
| dec_off_a | input | OFF_W | First output offset |
| dec_off_b | input | OFF_W | Second offset, relative to the first destination |
| res_vld | output | 1 | Resolution result valid |
| res_ret | output | 1 | Instruction ends its block |
| res_a_vld | output | 1 | First destination valid |
| res_b_vld | output | 1 | Second destination valid |
| res_a_idx | output | IDX_W | First destination index |
| res_b_idx | output | IDX_W | Second destination index |
| exp_we | input | 1 | Write an expected input count |
| exp_idx | input | IDX_W | Instruction index for the count |
| exp_cnt | input | 3 | Expected number of inputs, 1 to 4 |
| arr0_vld | input | 1 | Arrival port 0 valid |
| arr0_src | input | IDX_W | Producer index on port 0 |
| arr0_dst | input | IDX_W | Destination index on port 0 |
| arr0_data | input | DATA_W | Value on port 0 |
| arr1_vld | input | 1 | Arrival port 1 valid |
| arr1_src | input | IDX_W | Producer index on port 1 |
| arr1_dst | input | IDX_W | Destination index on port 1 |
| arr1_data | input | DATA_W | Value on port 1 |
| rdy_vld | output | 1 | A complete instruction is offered |
| rdy_idx | output | IDX_W | Index of the offered instruction |
| rdy_ops | output | 4*DATA_W | Ordered operands, position 0 lowest |
| rdy_acc | input | 1 | Downstream takes the offered instruction |
| err_ovf | output | 1 | An arrival was dropped last cycle |

## Verification
The in-line properties check on every cycle that a regular zero offset yields a return, that a compressed zero offset yields plus eight, and that a zero second offset lands on the first destination. They also check that a slot count never passes four, that a full slot keeps its operands when hit, that the first arrival lands in position 0, and that an accepted slot is left empty. The tie-break between two same-cycle producers, the lowest-slot-first offer order, the tag returned with a ready slot, and index wrap-around only show up in the bench's directed scenarios, which compare the operand bus against hand-computed positions.

// File: rtl/dst_pkg.sv
package dst_pkg;
    localparam int MAX_OPS       = 4;
    localparam int CNT_W         = 3;
    localparam int OP_SEL_W      = $clog2(MAX_OPS);
    localparam int CMP_ZERO_JUMP = 8;

    typedef enum logic [1:0] {
        DK_IDLE = 2'd0,
        DK_FWD  = 2'd1,
        DK_RET  = 2'd2
    } dst_kind_e;

    function automatic logic arrival_swap(input logic v0, input logic v1,
                                          input logic [31:0] s0, input logic [31:0] s1);
        return v0 && v1 && (s1 < s0);
    endfunction
endpackage

// File: rtl/dst_offset_calc.sv
module dst_offset_calc
    import dst_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_cmp,
    input  logic             in_two,
    input  logic [IDX_W-1:0] cur,
    input  logic [OFF_W-1:0] off_a,
    input  logic [OFF_W-1:0] off_b,
    output logic             res_vld,
    output logic             res_ret,
    output logic             res_a_vld,
    output logic             res_b_vld,
    output logic [IDX_W-1:0] res_a,
    output logic [IDX_W-1:0] res_b
);
    localparam int PAD_W = IDX_W - OFF_W;

    dst_kind_e        kind;
    logic [IDX_W-1:0] eff_a;
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;

    always_comb begin
        kind  = DK_IDLE;
        eff_a = {{PAD_W{1'b0}}, off_a};
        if (in_vld) begin
            if (off_a == '0) begin
                if (in_cmp) begin
                    eff_a = IDX_W'(CMP_ZERO_JUMP);
                    kind  = DK_FWD;
                end else begin
                    kind  = DK_RET;
                end
            end else begin
                kind = DK_FWD;
            end
        end
        a_idx = cur + eff_a;
        b_idx = a_idx + {{PAD_W{1'b0}}, off_b};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld   <= 1'b0;
            res_ret   <= 1'b0;
            res_a_vld <= 1'b0;
            res_b_vld <= 1'b0;
            res_a     <= '0;
            res_b     <= '0;
        end else begin
            res_vld   <= in_vld;
            res_ret   <= (kind == DK_RET);
            res_a_vld <= (kind == DK_FWD);
            res_b_vld <= (kind == DK_FWD) && in_two;
            if (in_vld) begin
                res_a <= a_idx;
                res_b <= b_idx;
            end
        end
    end

    a_r3_reg_zero_ret: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !in_cmp && off_a == '0) |=> (res_ret && !res_a_vld && !res_b_vld));

    a_r4_cmp_jump: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_cmp && off_a == '0) |=>
            (!res_ret && res_a_vld && res_a == $past(cur) + IDX_W'(CMP_ZERO_JUMP)));

    a_r5_same_dest: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_two && off_b == '0 && (in_cmp || off_a != '0)) |=>
            (res_b_vld && res_b == res_a));
endmodule

// File: rtl/dst_slot.sv
module dst_slot
    import dst_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      exp_we,
    input  logic [CNT_W-1:0]          exp_cnt,
    input  logic [IDX_W-1:0]          exp_tag,
    input  logic                      hit_a,
    input  logic [DATA_W-1:0]         data_a,
    input  logic                      hit_b,
    input  logic [DATA_W-1:0]         data_b,
    output logic                      rdy,
    output logic [IDX_W-1:0]          tag,
    output logic [MAX_OPS*DATA_W-1:0] ops,
    output logic                      ovf
);
    logic [CNT_W-1:0]                      cnt_q, cnt_n;
    logic [CNT_W-1:0]                      exp_q, exp_n;
    logic [IDX_W-1:0]                      tag_q, tag_n;
    logic [MAX_OPS-1:0][DATA_W-1:0]        ops_q, ops_n;

    always_comb begin
        cnt_n = clr ? '0 : cnt_q;
        exp_n = clr ? '0 : exp_q;
        tag_n = tag_q;
        ops_n = ops_q;
        ovf   = 1'b0;
        if (exp_we) begin
            exp_n = exp_cnt;
            tag_n = exp_tag;
        end
        if (hit_a) begin
            if (cnt_n < CNT_W'(MAX_OPS)) begin
                ops_n[cnt_n[OP_SEL_W-1:0]] = data_a;
                cnt_n = cnt_n + 1'b1;
            end else begin
                ovf = 1'b1;
            end
        end
        if (hit_b) begin
            if (cnt_n < CNT_W'(MAX_OPS)) begin
                ops_n[cnt_n[OP_SEL_W-1:0]] = data_b;
                cnt_n = cnt_n + 1'b1;
            end else begin
                ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= '0;
            tag_q <= '0;
            ops_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            exp_q <= exp_n;
            tag_q <= tag_n;
            ops_q <= ops_n;
        end
    end

    assign rdy = (exp_q != '0) && (cnt_q == exp_q);
    assign tag = tag_q;
    assign ops = ops_q;

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_OPS));

    a_r6_first_pos: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt_q == '0 && hit_a) |=> (ops_q[0] == $past(data_a)));

    a_r9_full_drop: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt_q == CNT_W'(MAX_OPS) && (hit_a || hit_b)) |=>
            (cnt_q == CNT_W'(MAX_OPS) && $stable(ops_q)));

    a_r10_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit_a && !hit_b && !exp_we) |=> (cnt_q == '0 && !rdy));
endmodule

// File: rtl/dst_ready_pick.sv
module dst_ready_pick #(
    parameter int N     = 16,
    parameter int SEL_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [SEL_W-1:0] sel
);
    always_comb begin
        any = |req;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) sel = SEL_W'(i);
        end
    end
endmodule

// File: rtl/dflow_dest_resolver.sv
module dflow_dest_resolver
    import dst_pkg::*;
#(
    parameter int IDX_W     = 16,
    parameter int OFF_W     = 6,
    parameter int DATA_W    = 16,
    parameter int NUM_SLOTS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dec_vld,
    input  logic                      dec_cmp,
    input  logic                      dec_two,
    input  logic [IDX_W-1:0]          dec_cur,
    input  logic [OFF_W-1:0]          dec_off_a,
    input  logic [OFF_W-1:0]          dec_off_b,
    output logic                      res_vld,
    output logic                      res_ret,
    output logic                      res_a_vld,
    output logic                      res_b_vld,
    output logic [IDX_W-1:0]          res_a_idx,
    output logic [IDX_W-1:0]          res_b_idx,
    input  logic                      exp_we,
    input  logic [IDX_W-1:0]          exp_idx,
    input  logic [2:0]                exp_cnt,
    input  logic                      arr0_vld,
    input  logic [IDX_W-1:0]          arr0_src,
    input  logic [IDX_W-1:0]          arr0_dst,
    input  logic [DATA_W-1:0]         arr0_data,
    input  logic                      arr1_vld,
    input  logic [IDX_W-1:0]          arr1_src,
    input  logic [IDX_W-1:0]          arr1_dst,
    input  logic [DATA_W-1:0]         arr1_data,
    output logic                      rdy_vld,
    output logic [IDX_W-1:0]          rdy_idx,
    output logic [4*DATA_W-1:0]       rdy_ops,
    input  logic                      rdy_acc,
    output logic                      err_ovf
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    dst_offset_calc #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_calc (
        .clk(clk), .rst(rst),
        .in_vld(dec_vld), .in_cmp(dec_cmp), .in_two(dec_two),
        .cur(dec_cur), .off_a(dec_off_a), .off_b(dec_off_b),
        .res_vld(res_vld), .res_ret(res_ret),
        .res_a_vld(res_a_vld), .res_b_vld(res_b_vld),
        .res_a(res_a_idx), .res_b(res_b_idx)
    );

    // arrival ordering: the lower producer index goes first
    logic                 swap;
    logic                 f_vld, s_vld;
    logic [SLOT_W-1:0]    f_slot, s_slot;
    logic [DATA_W-1:0]    f_data, s_data;

    always_comb begin
        swap   = arrival_swap(arr0_vld, arr1_vld, 32'(arr0_src), 32'(arr1_src));
        f_vld  = swap ? arr1_vld : arr0_vld;
        f_slot = swap ? arr1_dst[SLOT_W-1:0] : arr0_dst[SLOT_W-1:0];
        f_data = swap ? arr1_data : arr0_data;
        s_vld  = swap ? arr0_vld : arr1_vld;
        s_slot = swap ? arr0_dst[SLOT_W-1:0] : arr1_dst[SLOT_W-1:0];
        s_data = swap ? arr0_data : arr1_data;
    end

    logic [NUM_SLOTS-1:0]          slot_rdy;
    logic [NUM_SLOTS-1:0]          slot_ovf;
    logic [IDX_W-1:0]              slot_tag [NUM_SLOTS];
    logic [MAX_OPS*DATA_W-1:0]     slot_ops [NUM_SLOTS];
    logic                          pick_any;
    logic [SLOT_W-1:0]             pick_sel;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit_f, hit_s, clr_g, we_g;
        assign hit_f = f_vld && (f_slot == SLOT_W'(g));
        assign hit_s = s_vld && (s_slot == SLOT_W'(g));
        assign clr_g = pick_any && rdy_acc && (pick_sel == SLOT_W'(g));
        assign we_g  = exp_we && (exp_idx[SLOT_W-1:0] == SLOT_W'(g));

        dst_slot #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst(rst), .clr(clr_g),
            .exp_we(we_g), .exp_cnt(exp_cnt), .exp_tag(exp_idx),
            .hit_a(hit_f), .data_a(f_data),
            .hit_b(hit_s), .data_b(s_data),
            .rdy(slot_rdy[g]), .tag(slot_tag[g]), .ops(slot_ops[g]),
            .ovf(slot_ovf[g])
        );
    end

    dst_ready_pick #(.N(NUM_SLOTS), .SEL_W(SLOT_W)) u_pick (
        .req(slot_rdy), .any(pick_any), .sel(pick_sel)
    );

    assign rdy_vld = pick_any;
    assign rdy_idx = slot_tag[pick_sel];
    assign rdy_ops = slot_ops[pick_sel];

    always_ff @(posedge clk) begin
        if (rst) err_ovf <= 1'b0;
        else     err_ovf <= |slot_ovf;
    end

    a_r9_err_cause: assert property (@(posedge clk) disable iff (rst)
        err_ovf |-> $past(arr0_vld || arr1_vld));

    a_r8_offer_ready: assert property (@(posedge clk) disable iff (rst)
        rdy_vld |-> slot_rdy[pick_sel]);
endmodule

// File: tb/test_dflow_dest_resolver.sv
`timescale 1ns/1ps
module test_dflow_dest_resolver;
    localparam int IDX_W = 16, OFF_W = 6, DATA_W = 16, NV = 8;

    logic clk = 1'b0, rst = 1'b1;
    always #2.5 clk = ~clk;

    logic dec_vld, dec_cmp, dec_two;
    logic [IDX_W-1:0] dec_cur;
    logic [OFF_W-1:0] dec_off_a, dec_off_b;
    logic res_vld, res_ret, res_a_vld, res_b_vld;
    logic [IDX_W-1:0] res_a_idx, res_b_idx;
    logic exp_we;
    logic [IDX_W-1:0] exp_idx;
    logic [2:0] exp_cnt;
    logic arr0_vld, arr1_vld;
    logic [IDX_W-1:0] arr0_src, arr0_dst, arr1_src, arr1_dst;
    logic [DATA_W-1:0] arr0_data, arr1_data;
    logic rdy_vld, rdy_acc, err_ovf;
    logic [IDX_W-1:0] rdy_idx;
    logic [4*DATA_W-1:0] rdy_ops;

    dflow_dest_resolver i_dflow_dest_resolver (.*);

    int total = 0, bad = 0;

    // cur, off_a, off_b, cmp, two -> ret, a_vld, b_vld, a_idx, b_idx
    localparam int V_CUR [NV] = '{10, 10, 20, 20, 20, 65535, 100, 7};
    localparam int V_OA  [NV] = '{1, 5, 0, 0, 0, 1, 63, 3};
    localparam int V_OB  [NV] = '{0, 3, 4, 0, 2, 1, 0, 0};
    localparam int V_CMP [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};
    localparam int V_TWO [NV] = '{1, 1, 1, 0, 1, 1, 0, 0};
    localparam int E_RET [NV] = '{0, 0, 1, 0, 0, 0, 0, 0};
    localparam int E_AV  [NV] = '{1, 1, 0, 1, 1, 1, 1, 1};
    localparam int E_BV  [NV] = '{1, 1, 0, 0, 1, 1, 0, 0};
    localparam int E_A   [NV] = '{11, 15, 0, 28, 28, 0, 163, 10};
    localparam int E_B   [NV] = '{11, 18, 0, 0, 30, 1, 0, 0};

    task automatic chk(input logic ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        dec_vld = 0; dec_cmp = 0; dec_two = 0; dec_cur = '0; dec_off_a = '0; dec_off_b = '0;
        exp_we = 0; exp_idx = '0; exp_cnt = '0;
        arr0_vld = 0; arr0_src = '0; arr0_dst = '0; arr0_data = '0;
        arr1_vld = 0; arr1_src = '0; arr1_dst = '0; arr1_data = '0;
        rdy_acc = 0;
    endtask

    function automatic logic [DATA_W-1:0] op(input int k);
        return rdy_ops[k*DATA_W +: DATA_W];
    endfunction

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_in();
        @(negedge clk);
        tick(); tick(); tick();
        // R1 reset state
        chk(!res_vld, "R1 res_vld", res_vld, 0);
        chk(!rdy_vld, "R1 rdy_vld", rdy_vld, 0);
        chk(!err_ovf, "R1 err_ovf", err_ovf, 0);
        rst = 0;
        tick();

        // R2 R3 R4 R5 offset vectors
        for (int v = 0; v < NV; v++) begin
            dec_vld = 1; dec_cur = IDX_W'(V_CUR[v]);
            dec_off_a = OFF_W'(V_OA[v]); dec_off_b = OFF_W'(V_OB[v]);
            dec_cmp = V_CMP[v][0]; dec_two = V_TWO[v][0];
            tick();
            chk(res_vld, "R2 res_vld", res_vld, 1);
            chk(res_ret == E_RET[v][0], "R3 return flag", res_ret, E_RET[v]);
            chk(res_a_vld == E_AV[v][0], "R4 dest A valid", res_a_vld, E_AV[v]);
            chk(res_b_vld == E_BV[v][0], "R5 dest B valid", res_b_vld, E_BV[v]);
            if (E_AV[v] != 0)
                chk(res_a_idx == IDX_W'(E_A[v]), "R2 dest A index", res_a_idx, E_A[v]);
            if (E_BV[v] != 0)
                chk(res_b_idx == IDX_W'(E_B[v]), "R5 dest B index", res_b_idx, E_B[v]);
        end
        idle_in();
        tick();
        chk(!res_vld, "R2 idle", res_vld, 0);

        // R6 R7: slot 3, three inputs, pair in one cycle
        exp_we = 1; exp_idx = 16'd3; exp_cnt = 3'd3;
        arr0_vld = 1; arr0_src = 16'd9; arr0_dst = 16'd3; arr0_data = 16'hA1;
        tick();
        idle_in();
        chk(!rdy_vld, "R8 not yet ready", rdy_vld, 0);
        arr0_vld = 1; arr0_src = 16'd8; arr0_dst = 16'd3; arr0_data = 16'hB2;
        arr1_vld = 1; arr1_src = 16'd2; arr1_dst = 16'd3; arr1_data = 16'hC3;
        tick();
        idle_in();
        chk(rdy_vld, "R8 ready", rdy_vld, 1);
        chk(rdy_idx == 16'd3, "R8 ready index", rdy_idx, 3);
        chk(op(0) == 16'hA1, "R6 position 0", op(0), 16'hA1);
        chk(op(1) == 16'hC3, "R7 lower producer first", op(1), 16'hC3);
        chk(op(2) == 16'hB2, "R7 higher producer second", op(2), 16'hB2);

        // R8 lowest slot first; slot 5 via tag 21, port 1 only
        exp_we = 1; exp_idx = 16'd21; exp_cnt = 3'd1;
        arr1_vld = 1; arr1_src = 16'd4; arr1_dst = 16'd21; arr1_data = 16'h55;
        tick();
        idle_in();
        chk(rdy_idx == 16'd3, "R8 lowest slot offered", rdy_idx, 3);
        rdy_acc = 1;
        tick();
        rdy_acc = 0;
        chk(rdy_vld && rdy_idx == 16'd21, "R10 next slot after accept", rdy_idx, 21);
        chk(op(0) == 16'h55, "R6 single operand", op(0), 16'h55);
        rdy_acc = 1;
        tick();
        rdy_acc = 0;
        chk(!rdy_vld, "R10 all cleared", rdy_vld, 0);

        // R9 overflow on slot 7
        exp_we = 1; exp_idx = 16'd7; exp_cnt = 3'd4;
        arr0_vld = 1; arr0_src = 16'd1; arr0_dst = 16'd7; arr0_data = 16'h11;
        arr1_vld = 1; arr1_src = 16'd2; arr1_dst = 16'd7; arr1_data = 16'h22;
        tick();
        idle_in();
        arr0_vld = 1; arr0_src = 16'd3; arr0_dst = 16'd7; arr0_data = 16'h33;
        arr1_vld = 1; arr1_src = 16'd3; arr1_dst = 16'd7; arr1_data = 16'h44;
        tick();
        idle_in();
        chk(rdy_vld && rdy_idx == 16'd7, "R8 four inputs ready", rdy_idx, 7);
        chk(op(3) == 16'h44, "R7 tie keeps port order", op(3), 16'h44);
        chk(!err_ovf, "R9 no error yet", err_ovf, 0);
        arr0_vld = 1; arr0_src = 16'd5; arr0_dst = 16'd7; arr0_data = 16'h99;
        tick();
        idle_in();
        chk(err_ovf, "R9 overflow flagged", err_ovf, 1);
        chk(op(0) == 16'h11 && op(1) == 16'h22 && op(2) == 16'h33 && op(3) == 16'h44,
            "R9 operands unchanged", rdy_ops, 64'h0044_0033_0022_0011);
        tick();
        chk(!err_ovf, "R9 error is a pulse", err_ovf, 0);
        rdy_acc = 1;
        tick();
        rdy_acc = 0;

        // R8 partial slot never offered
        exp_we = 1; exp_idx = 16'd9; exp_cnt = 3'd2;
        arr0_vld = 1; arr0_src = 16'd1; arr0_dst = 16'd9; arr0_data = 16'h77;
        tick();
        idle_in();
        tick();
        chk(!rdy_vld, "R8 partial not ready", rdy_vld, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule